// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between a processor core and a single-ported memory. Committed stores are queued in a small circular queue and leave for memory one at a time, oldest first, whenever the memory port is free. Loads are given the port ahead of queued stores, so a load to an address with nothing queued can reach memory before older stores to other addresses.

Every load address is compared with all queued store addresses. When any match, the value of the most recent matching store is returned one cycle later and memory is not read. Only one load that went to memory may be outstanding; its data is passed back when memory answers. An empty flag tells the core that no stores are still on their way, which is what a fence waits for. The queue depth must be a power of two.

Top module: `stbuf_bypass`

## Requirements
- R1: After reset, `empty`=1, `st_ready`=1, `mem_req`=0 and `ld_rvalid`=0.
- R2: Stores are written to memory (`mem_req`=1, `mem_we`=1) in the order accepted, one per cycle with `mem_gnt`=1, with address and data unchanged.
- R3: With DEPTH stores queued, `st_ready` is 0 and a store offered then is not accepted and never reaches memory.
- R4: A load that matches no queued store is presented on the memory port (`mem_we`=0) in place of a queued store, so it is granted before any queued store is written.
- R5: A load that matches a queued store is accepted in the cycle it is offered regardless of `mem_gnt`, causes no memory read, and its data appears with `ld_rvalid`=1 in the following cycle.
- R6: When several queued stores match the load address, the data of the most recently accepted one is returned.
- R7: For a load sent to memory, `ld_rvalid` is raised in the cycle `mem_rvalid` is 1 and `ld_rdata` equals `mem_rdata`.
- R8: `empty` is 1 exactly when no accepted store is still unwritten; no store write is requested while it is 1.
- R9: While a load sent to memory awaits its data, `ld_ready` stays 0.
- R10: A store accepted in the same cycle as a load is ordered after that load: the load does not see its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load accepted when high with ld_valid |
| ld_addr | input | AW | Load address |
| ld_rvalid | output | 1 | Load data valid |
| ld_rdata | output | DW | Load data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write (store drain), 0 = read (load) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| empty | output | 1 | No stores pending |

## Verification
The hardest situation to reach is a full queue holding two stores to one address while a load to that address, and then a load to a fresh address, arrive: this needs memory to refuse grants for long enough. The bench holds its memory model's grant low while it fills the queue with a repeated address, probes the forwarding path, then raises grant in the same cycle as a missing load so the load and the oldest store compete for the port. The write log kept by the memory model then shows whether the load overtook the stores and whether the drain order held.

// File: rtl/stbuf_bypass.sv
module stbuf_bypass #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_rvalid,
  output logic [DW-1:0] ld_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0] ent_a [DEPTH];
  logic [DW-1:0] ent_d [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          pend;
  logic          fwd_v;
  logic [DW-1:0] fwd_d;

  logic          hit;
  logic [DW-1:0] hit_d;
  logic          miss_req;
  logic          push, pop;

  always_comb begin
    logic [PW-1:0] idx;
    hit   = 1'b0;
    hit_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + PW'(i);
      if (CW'(i) < count && ent_a[idx] == ld_addr) begin
        hit   = 1'b1;
        hit_d = ent_d[idx];
      end
    end
  end

  assign empty     = (count == '0);
  assign st_ready  = (count != CW'(DEPTH));
  assign miss_req  = ld_valid && !pend && !hit;
  assign mem_req   = miss_req || !empty;
  assign mem_we    = !miss_req;
  assign mem_addr  = miss_req ? ld_addr : ent_a[rd_ptr];
  assign mem_wdata = ent_d[rd_ptr];
  assign ld_ready  = ld_valid && !pend && (hit || mem_gnt);
  assign push      = st_valid && st_ready;
  assign pop       = mem_gnt && mem_req && mem_we;
  assign ld_rvalid = fwd_v || (pend && mem_rvalid);
  assign ld_rdata  = fwd_v ? fwd_d : mem_rdata;

  always_ff @(posedge clk) begin
    if (push) begin
      ent_a[wr_ptr] <= st_addr;
      ent_d[wr_ptr] <= st_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      pend   <= 1'b0;
      fwd_v  <= 1'b0;
      fwd_d  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (miss_req && mem_gnt) pend <= 1'b1;
      else if (mem_rvalid)     pend <= 1'b0;
      fwd_v <= ld_valid && !pend && hit;
      if (ld_valid && !pend && hit) fwd_d <= hit_d;
    end
  end
endmodule

module stbuf_checks #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_ready,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          ld_rvalid,
  input logic [DW-1:0] ld_rdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rvalid,
  input logic [DW-1:0] mem_rdata,
  input logic          empty,
  input logic          pend
);
  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !empty);
  a_r4_load_takes_port: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && ld_valid) |-> (ld_ready || pend));
  a_r5_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !(mem_req && !mem_we)) |=> ld_rvalid);
  a_r7_mem_data_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && mem_rvalid) |-> (ld_rvalid && ld_rdata == mem_rdata));
  a_r8_no_drain_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !(mem_req && mem_we));
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !ld_ready);
endmodule

bind stbuf_bypass stbuf_checks #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_rvalid(mem_rvalid),
  .mem_rdata(mem_rdata), .empty(empty), .pend(pend)
);

// File: tb/stbuf_bypass_bench.sv
module stbuf_bypass_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, ld_valid = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, ld_ready, ld_rvalid, mem_req, mem_we, mem_gnt, empty;
  logic [DW-1:0] ld_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 0, rv_d1 = 0;
  logic [DW-1:0] mem_rdata = '0, rd_d1 = '0;
  logic gnt_en = 0;

  int errors = 0, checks = 0, wn = 0, rn = 0;
  logic done = 0;
  logic [DW-1:0] mem [1 << AW];
  logic [AW-1:0] wlog_a [64];
  logic [DW-1:0] wlog_d [64];

  always #10 clk = ~clk;

  assign mem_gnt = mem_req && gnt_en;

  stbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_stbuf_bypass (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rvalid(ld_rvalid),
    .ld_rdata(ld_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .empty(empty));

  function automatic logic [DW-1:0] init_val(input int a);
    return 32'hA000_0000 | a;
  endfunction

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);

  always @(posedge clk) begin
    rv_d1      <= 1'b0;
    mem_rvalid <= rv_d1;
    mem_rdata  <= rd_d1;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (wn < 64) begin
          wlog_a[wn] <= mem_addr;
          wlog_d[wn] <= mem_wdata;
        end
        wn <= wn + 1;
      end else begin
        rd_d1 <= mem[mem_addr];
        rv_d1 <= 1'b1;
        rn    <= rn + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); st_valid = 1; st_addr = a; st_data = d; #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(negedge clk); st_valid = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic grant_too,
                         output logic [DW-1:0] d, output logic went_mem);
    @(negedge clk); ld_valid = 1; ld_addr = a; if (grant_too) gnt_en = 1; #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    went_mem = mem_req && !mem_we;
    @(negedge clk); ld_valid = 0; #1;
    while (!ld_rvalid) begin @(negedge clk); #1; end
    d = ld_rdata;
  endtask

  task automatic wait_empty;
    @(negedge clk); #1;
    while (!empty) begin @(negedge clk); #1; end
  endtask

  task automatic t_reset;
    chk(empty == 1, "R1 empty", DW'(empty), 1);
    chk(st_ready == 1, "R1 st_ready", DW'(st_ready), 1);
    chk(mem_req == 0, "R1 mem_req", DW'(mem_req), 0);
    chk(ld_rvalid == 0, "R1 ld_rvalid", DW'(ld_rvalid), 0);
  endtask

  localparam logic [AW-1:0] FA [8] = '{8'h10, 8'h11, 8'h12, 8'h10, 8'h13, 8'h14, 8'h15, 8'h16};

  task automatic t_fill_forward_drain;
    logic [DW-1:0] d;
    logic wm;
    int r0;
    gnt_en = 0;
    for (int i = 0; i < DEPTH; i++) do_store(FA[i], 32'hD000_0000 + i);
    #1;
    chk(st_ready == 0, "R3 full st_ready", DW'(st_ready), 0);
    chk(empty == 0, "R8 not empty", DW'(empty), 0);
    @(negedge clk); st_valid = 1; st_addr = 8'h20; st_data = 32'hBAD0_BAD0;
    for (int k = 0; k < 3; k++) begin
      #1; chk(st_ready == 0, "R3 extra store held off", DW'(st_ready), 0);
      @(negedge clk);
    end
    st_valid = 0;
    r0 = rn;
    do_load(8'h10, 0, d, wm);
    chk(d == 32'hD000_0003, "R6 youngest match", d, 32'hD000_0003);
    chk(wm == 0, "R5 no memory read on hit", DW'(wm), 0);
    do_load(8'h12, 0, d, wm);
    chk(d == 32'hD000_0002, "R5 forwarded data", d, 32'hD000_0002);
    chk(rn == r0, "R5 read count unchanged", DW'(rn), DW'(r0));
    do_load(8'h40, 1, d, wm);
    chk(wm == 1, "R4 miss uses memory", DW'(wm), 1);
    chk(d == init_val(8'h40), "R7 miss data", d, init_val(8'h40));
    chk(wlog_a[0] == FA[0], "R4 load before first write", DW'(wlog_a[0]), DW'(FA[0]));
    wait_empty;
    chk(wn == DEPTH, "R3 write count", DW'(wn), DW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      chk(wlog_a[i] == FA[i] && wlog_d[i] == 32'hD000_0000 + i, "R2 drain order",
          {wlog_a[i], wlog_d[i][23:0]}, {FA[i], 24'(i)});
    end
    chk(mem_req == 0, "R8 idle when empty", DW'(mem_req), 0);
  endtask

  task automatic t_load_wins_order;
    logic [DW-1:0] d;
    logic wm;
    int w0;
    gnt_en = 0;
    do_store(8'h50, 32'h1111_0000);
    w0 = wn;
    @(negedge clk); ld_valid = 1; ld_addr = 8'h51; gnt_en = 1; #1;
    chk(mem_req && !mem_we, "R4 read presented over pending store", DW'({mem_req, mem_we}), 2);
    @(negedge clk); ld_valid = 0; #1;
    chk(wn == w0, "R4 store not written yet", DW'(wn), DW'(w0));
    while (!ld_rvalid) begin @(negedge clk); #1; end
    chk(ld_rdata == init_val(8'h51), "R7 read data", ld_rdata, init_val(8'h51));
    wait_empty;
    chk(mem[8'h50] == 32'h1111_0000, "R2 store reached memory", mem[8'h50], 32'h1111_0000);
    do_load(8'h50, 1, d, wm);
    chk(d == 32'h1111_0000 && wm == 1, "R8 drained value read back", d, 32'h1111_0000);
  endtask

  task automatic t_single_outstanding;
    gnt_en = 1;
    @(negedge clk); ld_valid = 1; ld_addr = 8'h60; #1;
    chk(ld_ready == 1, "R9 first load accepted", DW'(ld_ready), 1);
    @(negedge clk); ld_addr = 8'h61; #1;
    chk(ld_ready == 0, "R9 second load held", DW'(ld_ready), 0);
    while (!ld_rvalid) begin @(negedge clk); #1; end
    chk(ld_rdata == init_val(8'h60), "R9 first data", ld_rdata, init_val(8'h60));
    while (!ld_ready) begin @(negedge clk); #1; end
    @(negedge clk); ld_valid = 0; #1;
    while (!ld_rvalid) begin @(negedge clk); #1; end
    chk(ld_rdata == init_val(8'h61), "R9 second data", ld_rdata, init_val(8'h61));
  endtask

  task automatic t_same_cycle;
    gnt_en = 1;
    @(negedge clk);
    st_valid = 1; st_addr = 8'h30; st_data = 32'h5555_5555;
    ld_valid = 1; ld_addr = 8'h30; #1;
    chk(ld_ready && st_ready, "R10 both accepted", DW'({ld_ready, st_ready}), 3);
    @(negedge clk); st_valid = 0; ld_valid = 0; #1;
    while (!ld_rvalid) begin @(negedge clk); #1; end
    chk(ld_rdata == init_val(8'h30), "R10 load sees older value", ld_rdata, init_val(8'h30));
    wait_empty;
    chk(mem[8'h30] == 32'h5555_5555, "R10 store written afterwards", mem[8'h30], 32'h5555_5555);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset;
    t_fill_forward_drain;
    t_load_wins_order;
    t_single_outstanding;
    t_same_cycle;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule